// File: doc/BRIEF.md
# PN Chip Spreader for I/Q Symbols

This block widens the spectrum of a baseband I/Q symbol. It runs on a chip-rate clock. A four-stage linear feedback shift register produces a pseudo-noise chip sequence that repeats every 15 chips. Each chip is turned into a sign: chip 0 leaves the symbol unchanged and chip 1 negates it. The signed 8-bit I and Q components are multiplied by that sign, and the results are registered as the spread outputs.

The block also divides the chip clock into two alignment strobes. The modulator strobe fires once every 5 chips. The symbol strobe fires once every 15 chips, on the first chip of the sequence. An upstream symbol source uses the strobes to present one new I/Q pair per sequence period. The pair on the inputs during the symbol-strobe cycle is spread straight away and also captured into a holding register. That register supplies the remaining 14 chips of the period.

Top module: `pn_chip_spreader`

## Requirements
- R1: After reset the chip output follows the sequence 0,0,0,1,0,0,1,1,0,1,0,1,1,1,1 and repeats it with period 15. The first chip after reset is the leftmost 0. This comes from a register seeded with only its top stage set.
- R2: When the applied chip is 0, `mi_o`/`mq_o` equal the symbol's I/Q unchanged. When the chip is 1, they equal the two's-complement negation of I/Q.
- R3: Negating the value -128 (0x80) gives +127 (0x7F) instead of wrapping.
- R4: The spread outputs are registered. The value for the chip shown in one cycle appears on `mi_o`/`mq_o` in the following cycle. Both outputs are 0 in reset and in the first cycle after reset.
- R5: `mod_en_o` is high on chip positions 0, 5 and 10 of each 15-chip period and low on every other position.
- R6: `sym_en_o` is high on chip position 0 only. It coincides with a `mod_en_o` pulse.
- R7: The I/Q pair present during the `sym_en_o` cycle is spread for all 15 chips of that period. Input changes during the other 14 cycles have no effect on the outputs.
- R8: Reset is asynchronous and active low. Asserting it forces chip position 0, chip value 0, both strobes high and zero outputs at once. After `rst_n` rises, the block stays at position 0 for two more clock edges before advancing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chip-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_in | input | 8 | In-phase symbol component, two's complement |
| q_in | input | 8 | Quadrature symbol component, two's complement |
| chip_o | output | 1 | Current PN chip |
| mod_en_o | output | 1 | Modulator-rate strobe, every 5 chips |
| sym_en_o | output | 1 | Symbol-rate strobe, every 15 chips |
| mi_o | output | 8 | Registered spread in-phase output |
| mq_o | output | 8 | Registered spread quadrature output |

## Verification
The bench compares the chip stream with a 15-entry reference. Wrong taps or a wrong seed would show up as a shifted or different pattern, or a period other than 15. Extreme symbol values of -128 and +127 exercise saturation: a design that wraps on negation would output -128 where +127 is due. The inputs are overwritten mid-period to expose a design that does not hold the symbol. Output timing is checked chip by chip, so an extra or missing pipeline stage would show up as a one-chip misalignment of the sign flips. A second reset is applied mid-period to check the asynchronous clear and the two-edge release.

// File: rtl/pn_spread_pkg.sv
package pn_spread_pkg;
  localparam int unsigned LFSR_W        = 4;
  localparam logic [3:0]  LFSR_SEED     = 4'b1000;
  localparam int unsigned CHIPS_PER_MOD = 5;
  localparam int unsigned MODS_PER_SYM  = 3;
  localparam int unsigned SAMPLE_W      = 8;
  localparam int unsigned LANES         = 2;
endpackage

// File: rtl/pn_lfsr.sv
module pn_lfsr #(
  parameter int unsigned     W     = 4,
  parameter logic [W-1:0]    SEED  = 4'b1000,
  parameter int unsigned     TAP_A = 0,
  parameter int unsigned     TAP_B = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic chip_o
);
  logic [W-1:0] state_q, state_d;

  always_comb begin
    state_d = {state_q[TAP_A] ^ state_q[TAP_B], state_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign chip_o = state_q[0];

  // R1: an all-zero state would lock the sequence
  p_lfsr_alive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
endmodule

// File: rtl/chip_phase.sv
module chip_phase #(
  parameter int unsigned CPM = 5,
  parameter int unsigned MPS = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic mod_en_o,
  output logic sym_en_o
);
  localparam int unsigned CW = (CPM > 1) ? $clog2(CPM) : 1;
  localparam int unsigned MW = (MPS > 1) ? $clog2(MPS) : 1;

  logic [CW-1:0] chip_cnt_q, chip_cnt_d;
  logic [MW-1:0] mod_cnt_q, mod_cnt_d;

  always_comb begin
    chip_cnt_d = chip_cnt_q;
    mod_cnt_d  = mod_cnt_q;
    if (chip_cnt_q == CW'(CPM - 1)) begin
      chip_cnt_d = '0;
      if (mod_cnt_q == MW'(MPS - 1)) mod_cnt_d = '0;
      else                           mod_cnt_d = mod_cnt_q + 1'b1;
    end else begin
      chip_cnt_d = chip_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chip_cnt_q <= '0;
      mod_cnt_q  <= '0;
    end else begin
      chip_cnt_q <= chip_cnt_d;
      mod_cnt_q  <= mod_cnt_d;
    end
  end

  assign mod_en_o = (chip_cnt_q == '0);
  assign sym_en_o = mod_en_o && (mod_cnt_q == '0);

  // R5: modulator strobes are isolated single-cycle pulses
  p_mod_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mod_en_o |=> !mod_en_o);
  // R6: symbol strobe is followed by a non-symbol chip
  p_sym_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sym_en_o |=> !sym_en_o);
endmodule

// File: rtl/sign_spread.sv
module sign_spread #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] din,
  input  logic         neg,
  output logic [W-1:0] dout
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  always_comb begin
    if (!neg)                 dout = din;
    else if (din == MOST_NEG) dout = MOST_POS;
    else                      dout = -din;
  end
endmodule

// File: rtl/pn_chip_spreader.sv
module pn_chip_spreader
  import pn_spread_pkg::*;
#(
  parameter int unsigned DW = SAMPLE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] i_in,
  input  logic [DW-1:0] q_in,
  output logic          chip_o,
  output logic          mod_en_o,
  output logic          sym_en_o,
  output logic [DW-1:0] mi_o,
  output logic [DW-1:0] mq_o
);
  logic [1:0] rst_sync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  logic chip;

  pn_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED), .TAP_A(0), .TAP_B(1)) u_lfsr (
    .clk(clk), .rst_n(rst_ns), .chip_o(chip)
  );

  logic mod_en, sym_en;

  chip_phase #(.CPM(CHIPS_PER_MOD), .MPS(MODS_PER_SYM)) u_phase (
    .clk(clk), .rst_n(rst_ns), .mod_en_o(mod_en), .sym_en_o(sym_en)
  );

  logic [DW-1:0] lane_in  [LANES];
  logic [DW-1:0] hold_q   [LANES];
  logic [DW-1:0] lane_sel [LANES];
  logic [DW-1:0] lane_sp  [LANES];
  logic [DW-1:0] out_q    [LANES];

  assign lane_in[0] = i_in;
  assign lane_in[1] = q_in;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_ns) begin
      if (!rst_ns)     hold_q[g] <= '0;
      else if (sym_en) hold_q[g] <= lane_in[g];
    end

    assign lane_sel[g] = sym_en ? lane_in[g] : hold_q[g];

    sign_spread #(.W(DW)) u_spread (
      .din(lane_sel[g]), .neg(chip), .dout(lane_sp[g])
    );

    always_ff @(posedge clk or negedge rst_ns) begin
      if (!rst_ns) out_q[g] <= '0;
      else         out_q[g] <= lane_sp[g];
    end

    // R7: held symbol only moves on a symbol strobe
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_ns)
      !sym_en |=> $stable(hold_q[g]));
    // R2: a zero chip passes the selected sample through one register
    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_ns)
      !chip |=> out_q[g] == $past(lane_sel[g]));
    // R3: negating the most negative value clamps to the most positive
    p_sat_r3: assert property (@(posedge clk) disable iff (!rst_ns)
      (chip && lane_sel[g] == {1'b1, {(DW-1){1'b0}}}) |=>
        out_q[g] == {1'b0, {(DW-1){1'b1}}});
  end

  assign chip_o   = chip;
  assign mod_en_o = mod_en;
  assign sym_en_o = sym_en;
  assign mi_o     = out_q[0];
  assign mq_o     = out_q[1];

  // R6: every symbol strobe falls on a modulator strobe
  p_sym_on_mod_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    sym_en |-> mod_en);
  // R1: each period starts on chip 0 (seed places 0 at the output stage)
  p_period_start_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    sym_en |-> !chip);
endmodule

// File: tb/test_pn_chip_spreader.sv
`timescale 1ns/1ps
module test_pn_chip_spreader;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] i_in, q_in;
  logic       chip_o, mod_en_o, sym_en_o;
  logic [7:0] mi_o, mq_o;

  int ntests = 0;
  int nfail  = 0;

  localparam logic [14:0] PN_REF = 15'b000100110101111;
  localparam int NSYM = 5;
  localparam logic [15:0] VEC [NSYM] = '{
    {8'h5B, 8'hA5},   // +91 / -91
    {8'h80, 8'h7F},   // -128 / +127
    {8'h00, 8'hFF},   // 0 / -1
    {8'h7F, 8'h80},   // +127 / -128
    {8'hFF, 8'h01}    // -1 / +1
  };

  always #2 clk = ~clk;

  pn_chip_spreader i_pn_chip_spreader (
    .clk(clk), .rst_n(rst_n), .i_in(i_in), .q_in(q_in),
    .chip_o(chip_o), .mod_en_o(mod_en_o), .sym_en_o(sym_en_o),
    .mi_o(mi_o), .mq_o(mq_o)
  );

  function automatic logic ref_chip(int idx);
    return PN_REF[14 - (idx % 15)];
  endfunction

  function automatic logic [7:0] ref_spread(logic [7:0] x, logic c);
    if (!c)          return x;
    if (x == 8'h80)  return 8'h7F;
    return 8'h00 - x;
  endfunction

  task automatic check(string tag, string what, logic [7:0] got, logic [7:0] exp);
    ntests++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %h expected %h at %0t", tag, what, got, exp, $time);
    end
  endtask

  initial begin
    #800000;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {i_in, q_in} = VEC[0];
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    check("R8", "chip in reset", {7'd0, chip_o}, 8'd0);
    check("R8", "sym_en in reset", {7'd0, sym_en_o}, 8'd1);
    check("R4", "mi in reset", mi_o, 8'd0);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    for (int j = 0; j < NSYM * 15; j++) begin
      logic [15:0] sym;
      logic        cp;
      string       tg;
      check("R1", "chip", {7'd0, chip_o}, {7'd0, ref_chip(j)});
      check("R6", "sym_en", {7'd0, sym_en_o}, {7'd0, (j % 15) == 0});
      check("R5", "mod_en", {7'd0, mod_en_o}, {7'd0, (j % 5) == 0});
      if (j == 0) begin
        check("R4", "mi first", mi_o, 8'd0);
        check("R4", "mq first", mq_o, 8'd0);
      end else begin
        sym = VEC[(j - 1) / 15];
        cp  = ref_chip(j - 1);
        if (cp && (sym[15:8] == 8'h80 || sym[7:0] == 8'h80)) tg = "R3";
        else if (((j - 1) % 15) > 7) tg = "R7";
        else tg = "R2";
        check(tg, "mi", mi_o, ref_spread(sym[15:8], cp));
        check(tg, "mq", mq_o, ref_spread(sym[7:0], cp));
      end
      if ((j % 15) == 0) {i_in, q_in} = VEC[j / 15];
      if ((j % 15) == 7) {i_in, q_in} = 16'h33CC;   // R7: ignored mid-period
      @(negedge clk);
    end
    // R8: asynchronous reset mid-period, then two-edge release
    repeat (3) @(negedge clk);
    {i_in, q_in} = VEC[1];
    #1 rst_n = 1'b0;
    #0.5;
    check("R8", "mi async clear", mi_o, 8'd0);
    check("R8", "mq async clear", mq_o, 8'd0);
    check("R8", "chip async clear", {7'd0, chip_o}, 8'd0);
    check("R8", "sym_en async", {7'd0, sym_en_o}, 8'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", "mod_en held edge1", {7'd0, mod_en_o}, 8'd1);
    @(negedge clk);
    check("R8", "mod_en held edge2", {7'd0, mod_en_o}, 8'd1);
    check("R8", "mi held edge2", mi_o, 8'd0);
    @(negedge clk);
    check("R8", "mod_en after release", {7'd0, mod_en_o}, 8'd0);
    check("R3", "mi first after release", mi_o, 8'h80);
    check("R3", "mq first after release", mq_o, 8'h7F);
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule